// File: doc/BRIEF.md
# Hierarchical Vertical-Crosswise Multiplier

This block multiplies two unsigned operands and returns their full-width product. It builds the product from a fixed recursion rather than from an array or a tree of partial products. The smallest element is a 2×2 cell made of four AND gates and two half adders. Each larger level splits both operands into a high half and a low half. It forms the four half-width sub-products with copies of the level below, then joins them with three ripple-carry adders. With the default width of 8, the block uses four 4×4 multipliers, and each of those uses four 2×2 cells.

The low half of the low×low sub-product passes straight to the bottom of the result. The first adder sums the two cross sub-products. The second adder adds that sum to a window made of the upper half of the low×low sub-product and the lower half of the high×high sub-product. The third adder folds both carries into the upper half of the high×high sub-product. A parameter selects either a purely combinational path or one output register, which gives one cycle of latency.

Top module: `vcm_mult`

## Requirements
- R1: With WIDTH=2 the product equals a×b for all 16 operand pairs. Product bit 3 is set only for 3×3 = 9, and in that case product bits 2 and 1 are both 0.
- R2: With WIDTH=4 the product equals a×b for all 256 operand pairs; in particular 15×15 gives 225.
- R3: With WIDTH=8 the product equals a×b for all 65536 operand pairs.
- R4: At every level above the 2×2 cell, the adder that forms the top half of the level's product never produces a carry out of its most significant bit.
- R5: Product bit 0 always equals op_a bit 0 AND op_b bit 0.
- R6: With REG_OUT=1 the product of the operands present at a rising clock edge appears on prod after that edge and holds until the next edge.
- R7: With REG_OUT=1, prod is 0 while rst_n is low, and it is cleared as soon as rst_n falls, without waiting for a clock edge.
- R8: A zero operand gives a zero product, and 255×255 gives 65025 (0xFE01) at WIDTH=8.
- R9: With REG_OUT=0 the product follows the operands in the same cycle, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | WIDTH | Unsigned multiplicand |
| op_b | input | WIDTH | Unsigned multiplier |
| prod | output | 2*WIDTH | Unsigned product |

## Verification
On every cycle, the assertions check four things. The 2×2 cell never sets its top bit together with a middle bit. No level's top adder carries out. Product bit 0 matches the AND of the operand LSBs. With the register present, prod equals the product of the operands from the previous edge, and prod stays at zero during reset. Only the bench's exhaustive sweeps show that the recursion is correct at each width, that is, that every sub-product lands at the right weight. The bench also covers the exact corner values: the all-ones operands, the zero operands and the 1111×1111 case. Separately, it shows that an asynchronous reset arriving mid-stream clears the output.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  // Operand width handled by the leaf cell of the recursion.
  localparam int unsigned VCM_LEAF_W = 2;

  // Product width for a given operand width.
  function automatic int unsigned vcm_prod_w(input int unsigned w);
    return 2 * w;
  endfunction
endpackage

// File: rtl/vcm_rca.sv
module vcm_rca #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
  end

  assign cout = carry[W];
endmodule

// File: rtl/vcm_cell2.sv
module vcm_cell2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic and_00, and_10, and_01, and_11;
  logic ha0_s, ha0_c, ha1_s, ha1_c;

  // Four bit products.
  assign and_00 = a[0] & b[0];
  assign and_10 = a[1] & b[0];
  assign and_01 = a[0] & b[1];
  assign and_11 = a[1] & b[1];

  // Crosswise half adder, then the carry joins the vertical top term.
  assign ha0_s = and_10 ^ and_01;
  assign ha0_c = and_10 & and_01;
  assign ha1_s = and_11 ^ ha0_c;
  assign ha1_c = and_11 & ha0_c;

  assign p = {ha1_c, ha1_s, ha0_s, and_00};

  // R1
  always_comb begin
    cell_top_bit_chk: assert (!p[3] || (p[2:1] == 2'b00))
      else $error("2x2 cell sets top bit with middle bits, p=%b", p);
  end
endmodule

// File: rtl/vcm_node.sv
module vcm_node #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [2*WIDTH-1:0] p
);
  import vcm_pkg::*;

  localparam int unsigned HALF = WIDTH / 2;

  if (WIDTH == VCM_LEAF_W) begin : g_leaf
    vcm_cell2 u_cell (
      .a (a),
      .b (b),
      .p (p)
    );
  end else begin : g_split
    logic [WIDTH-1:0] sub_ll, sub_lh, sub_hl, sub_hh;
    logic [WIDTH-1:0] cross_sum, mid_sum, window;
    logic             cross_c, mid_c;
    logic [HALF-1:0]  top_sum, top_add;
    logic             top_c;

    vcm_node #(.WIDTH(HALF)) u_ll (
      .a (a[HALF-1:0]), .b (b[HALF-1:0]), .p (sub_ll)
    );
    vcm_node #(.WIDTH(HALF)) u_lh (
      .a (a[HALF-1:0]), .b (b[WIDTH-1:HALF]), .p (sub_lh)
    );
    vcm_node #(.WIDTH(HALF)) u_hl (
      .a (a[WIDTH-1:HALF]), .b (b[HALF-1:0]), .p (sub_hl)
    );
    vcm_node #(.WIDTH(HALF)) u_hh (
      .a (a[WIDTH-1:HALF]), .b (b[WIDTH-1:HALF]), .p (sub_hh)
    );

    // Sum of the two crosswise sub-products.
    vcm_rca #(.W(WIDTH)) u_add_cross (
      .a (sub_lh), .b (sub_hl), .cin (1'b0),
      .sum (cross_sum), .cout (cross_c)
    );

    // Middle window: upper half of low*low next to lower half of high*high.
    assign window = {sub_hh[HALF-1:0], sub_ll[WIDTH-1:HALF]};

    vcm_rca #(.W(WIDTH)) u_add_mid (
      .a (cross_sum), .b (window), .cin (1'b0),
      .sum (mid_sum), .cout (mid_c)
    );

    // Both carries fold into the upper half of high*high.
    assign top_add = {{(HALF-1){1'b0}}, cross_c};

    vcm_rca #(.W(HALF)) u_add_top (
      .a (sub_hh[WIDTH-1:HALF]), .b (top_add), .cin (mid_c),
      .sum (top_sum), .cout (top_c)
    );

    assign p = {top_sum, mid_sum, sub_ll[HALF-1:0]};

    // R4
    always_comb begin
      no_overflow_chk: assert (!top_c)
        else $error("top adder carried out at width %0d", WIDTH);
    end
  end
endmodule

// File: rtl/vcm_mult.sv
module vcm_mult #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WIDTH-1:0]     op_a,
  input  logic [WIDTH-1:0]     op_b,
  output logic [2*WIDTH-1:0]   prod
);
  import vcm_pkg::*;

  localparam int unsigned PW = vcm_prod_w(WIDTH);

  logic [PW-1:0] prod_d;

  vcm_node #(.WIDTH(WIDTH)) u_tree (
    .a (op_a),
    .b (op_b),
    .p (prod_d)
  );

  if (REG_OUT) begin : g_reg
    logic [PW-1:0] prod_nxt, prod_q;

    always_comb begin
      prod_nxt = prod_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q <= '0;
      else        prod_q <= prod_nxt;
    end

    assign prod = prod_q;

    // R6
    latency_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (prod == PW'($past(op_a)) * PW'($past(op_b))))
      else $error("registered product does not match previous operands");

    // R7
    reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (prod == '0))
      else $error("product not cleared during reset");

    // R5
    lsb_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (prod[0] == ($past(op_a[0]) & $past(op_b[0]))))
      else $error("product bit 0 differs from operand LSB AND");
  end else begin : g_comb
    assign prod = prod_d;

    // R5
    lsb_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prod[0] == (op_a[0] & op_b[0]))
      else $error("product bit 0 differs from operand LSB AND");
  end
endmodule

// File: tb/vcm_mult_bench.sv
`timescale 1ns/1ps
module vcm_mult_bench;
  logic        clk;
  logic        rst_n;
  logic [7:0]  a8, b8;
  logic [3:0]  a4, b4;
  logic [1:0]  a2, b2;
  logic [15:0] prod_reg8, prod_comb8;
  logic [7:0]  prod4;
  logic [3:0]  prod2;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned cyc   = 0;
  bit          done  = 1'b0;

  vcm_mult #(.WIDTH(8), .REG_OUT(1'b1)) u_vcm_mult (
    .clk (clk), .rst_n (rst_n), .op_a (a8), .op_b (b8), .prod (prod_reg8)
  );
  vcm_mult #(.WIDTH(8), .REG_OUT(1'b0)) u_vcm_mult_comb8 (
    .clk (clk), .rst_n (rst_n), .op_a (a8), .op_b (b8), .prod (prod_comb8)
  );
  vcm_mult #(.WIDTH(4), .REG_OUT(1'b0)) u_vcm_mult_w4 (
    .clk (clk), .rst_n (rst_n), .op_a (a4), .op_b (b4), .prod (prod4)
  );
  vcm_mult #(.WIDTH(2), .REG_OUT(1'b0)) u_vcm_mult_w2 (
    .clk (clk), .rst_n (rst_n), .op_a (a2), .op_b (b2), .prod (prod2)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_prev;
    rst_n = 1'b0;
    a8 = 8'd0; b8 = 8'd0; a4 = 4'd0; b4 = 4'd0; a2 = 2'd0; b2 = 2'd0;
    exp_prev = '0;

    // R7: cleared during reset, even with nonzero operands
    repeat (2) @(negedge clk);
    a8 = 8'hA5; b8 = 8'h3C;
    @(negedge clk);
    chk("R7 reset state", prod_reg8, 16'd0);

    // R1: WIDTH=2 exhaustive
    for (int x = 0; x < 4; x++) begin
      for (int y = 0; y < 4; y++) begin
        a2 = 2'(x); b2 = 2'(y);
        #1;
        chk("R1 width2", {12'd0, prod2}, 16'(x * y));
        if (prod2[3]) chk("R1 top bit only for 9", {12'd0, prod2}, 16'd9);
      end
    end

    // R2: WIDTH=4 exhaustive
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        a4 = 4'(x); b4 = 4'(y);
        #1;
        chk("R2 width4", {8'd0, prod4}, 16'(x * y));
      end
    end
    a4 = 4'hF; b4 = 4'hF;
    #1;
    chk("R2 1111x1111", {8'd0, prod4}, 16'd225);

    // Release reset away from the edge
    @(negedge clk);
    rst_n = 1'b1;

    // R3/R4/R6/R9/R5: WIDTH=8 exhaustive sweep
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      if (i > 0) chk("R3/R4/R6 registered width8", prod_reg8, exp_prev);
      a8 = 8'(i >> 8);
      b8 = 8'(i);
      #1;
      exp_prev = 16'(a8) * 16'(b8);
      chk("R9 combinational width8", prod_comb8, exp_prev);
      if (prod_comb8[0] !== (a8[0] & b8[0]))
        chk("R5 bit0", {15'd0, prod_comb8[0]}, {15'd0, a8[0] & b8[0]});
    end
    @(negedge clk);
    chk("R6 last registered", prod_reg8, exp_prev);

    // R5: explicit LSB cases
    a8 = 8'h81; b8 = 8'h07; #1;
    chk("R5 bit0 odd*odd", {15'd0, prod_comb8[0]}, 16'd1);
    a8 = 8'h81; b8 = 8'h06; #1;
    chk("R5 bit0 odd*even", {15'd0, prod_comb8[0]}, 16'd0);

    // R8: corners
    a8 = 8'hFF; b8 = 8'hFF; #1;
    chk("R8 all ones", prod_comb8, 16'hFE01);
    a8 = 8'h00; b8 = 8'hFF; #1;
    chk("R8 zero a", prod_comb8, 16'd0);
    a8 = 8'hFF; b8 = 8'h00; #1;
    chk("R8 zero b", prod_comb8, 16'd0);

    // R6: holds between edges
    a8 = 8'hC3; b8 = 8'h5A;
    @(negedge clk);
    chk("R6 loaded", prod_reg8, 16'(8'hC3) * 16'(8'h5A));
    #1;
    a8 = 8'h11;
    #1;
    chk("R6 holds between edges", prod_reg8, 16'(8'hC3) * 16'(8'h5A));

    // R7: asynchronous clear mid-stream
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R7 async clear", prod_reg8, 16'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule